// File: doc/BRIEF.md
# Codec Register Access Bridge

This block links a byte-wide host register window to the register ports of up to two audio codecs. The host loads a 16-bit data word as two bytes. It picks a codec with a select bit in the status byte. It then writes a command byte that carries a register index and a direction bit. The bridge runs the access on a simple parallel request/acknowledge port to the selected codec, which stands in for the serial link. For reads it returns the codec's answer in the data word. Completed accesses are copied into a shadow register file, and the host can read that file back on a separate port.

Accesses to odd register indices never reach a codec. An odd read completes at once with a zero data word, and an odd write is dropped. A command aimed at a codec that is not present changes nothing. A second output reports which codecs are present. While a codec access is in flight the bridge is busy and ignores every host write.

Top module: `ac97_cmd_bridge`

## Requirements
- R1: Host window offsets are 0 = data low byte, 1 = data high byte, 2 = command, 3 = status. The data word is little-endian. Command bit 7 set means read, and bits 6:0 give the register index.
- R2: Status bit 6 selects the codec (0 or 1). If that codec's presence input is low, a command raises no request and leaves the data word, the status and the command readback unchanged.
- R3: A read of an even index asserts a request to the selected codec only. On acknowledge, the data word takes the codec's response and status bit 1 (codec 0) or bit 3 (codec 1) is set.
- R4: A write to an even index presents the index and the data word to the selected codec until it acknowledges. No valid bit is set.
- R5: A read of an odd index makes no codec request. It sets the data word to 0x0000 and sets the selected codec's valid bit.
- R6: A write to an odd index makes no codec request and changes neither the data word nor the shadow file.
- R7: The host writes status bits 7:6 directly. Bits 5:0 are set only by hardware, and host writes never clear them.
- R8: The presence output has bit 2*i set when codec i is present, and all other bits are zero.
- R9: Busy is high from the accepted even access until the codec acknowledges. Host writes to any offset are ignored while busy.
- R10: At most one codec request is high at a time. The index and write data stay stable until acknowledge.
- R11: On each completed codec access, the shadow word for (codec, index bits 6:1) takes the transferred value. The shadow read port returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 2 | Window offset for read and write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Window readback at host_addr |
| codec_present | input | 2 | Presence of each codec |
| present_status | output | 8 | Presence status byte |
| busy | output | 1 | Codec access in flight |
| cdc_req | output | 2 | Request to codec 0 / 1 |
| cdc_wr | output | 1 | Request is a write |
| cdc_idx | output | 7 | Codec register index |
| cdc_wdata | output | 16 | Codec write data |
| cdc_ack | input | 2 | Codec acknowledge, one cycle |
| cdc_rdata | input | 32 | Read data, codec 1 in bits 31:16 |
| shd_sel | input | 1 | Shadow read codec |
| shd_idx | input | 7 | Shadow read index |
| shd_rdata | output | 16 | Shadow word |

## Verification
The assertions assume three things about the inputs. The presence inputs hold still while a request is outstanding. A codec raises its acknowledge for exactly one cycle, and only while its own request is high. Nothing drives the host window during reset. The bench's codec model answers only a request it sees, then drops the acknowledge on the next cycle. The bench changes presence only between commands, once busy has fallen.

// File: rtl/acb_pkg.sv
package acb_pkg;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = 2 * BYTE_W;
    localparam int IDX_W   = BYTE_W - 1;
    localparam int NCODEC  = 2;
    localparam int SHD_DEP = 2 ** (IDX_W - 1);
    localparam int SHD_AW  = IDX_W - 1;

    localparam logic [1:0] OFS_DLO  = 2'd0;
    localparam logic [1:0] OFS_DHI  = 2'd1;
    localparam logic [1:0] OFS_CMD  = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    typedef enum logic {ST_IDLE, ST_WAIT} seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [DATA_W-1:0]   data;
        logic [BYTE_W-1:0]   stat;
        logic [BYTE_W-1:0]   cmd;
        logic                sel;
    } seq_state_t;
endpackage

// File: rtl/acb_presence.sv
module acb_presence
    import acb_pkg::*;
(
    input  logic [NCODEC-1:0] present,
    output logic [BYTE_W-1:0] status
);
    logic [BYTE_W-1:0] bits;
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if ((i % 2) == 0 && (i / 2) < NCODEC) begin : g_pres
            assign bits[i] = present[i/2];
        end else begin : g_zero
            assign bits[i] = 1'b0;
        end
    end
    assign status = bits;
endmodule

// File: rtl/acb_shadow.sv
module acb_shadow
    import acb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [NCODEC-1:0][DATA_W-1:0] rd_word;

    for (genvar c = 0; c < NCODEC; c++) begin : g_codec
        logic [DATA_W-1:0] mem_q [SHD_DEP];
        logic [DATA_W-1:0] mem_d [SHD_DEP];

        always_comb begin
            for (int w = 0; w < SHD_DEP; w++) begin
                mem_d[w] = mem_q[w];
            end
            if (wr_en && (wr_sel == c[0])) begin
                mem_d[wr_idx[IDX_W-1:1]] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            for (int w = 0; w < SHD_DEP; w++) begin
                if (!rst_n) mem_q[w] <= '0;
                else        mem_q[w] <= mem_d[w];
            end
        end

        assign rd_word[c] = mem_q[rd_idx[IDX_W-1:1]];
    end

    assign rd_data = rd_word[rd_sel];
endmodule

// File: rtl/acb_seq.sv
module acb_seq
    import acb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we,
    input  logic [1:0]               host_addr,
    input  logic [BYTE_W-1:0]        host_wdata,
    input  logic [NCODEC-1:0]        present,
    input  logic [NCODEC-1:0]        cdc_ack,
    input  logic [NCODEC*DATA_W-1:0] cdc_rdata,
    output logic [DATA_W-1:0]        data_out,
    output logic [BYTE_W-1:0]        stat_out,
    output logic [BYTE_W-1:0]        cmd_out,
    output logic                     busy,
    output logic [NCODEC-1:0]        cdc_req,
    output logic                     cdc_wr,
    output logic [IDX_W-1:0]         cdc_idx,
    output logic [DATA_W-1:0]        cdc_wdata,
    output logic                     shd_we,
    output logic                     shd_sel,
    output logic [IDX_W-1:0]         shd_idx,
    output logic [DATA_W-1:0]        shd_wdata
);
    seq_state_t r_q, r_d;
    logic [DATA_W-1:0] resp;
    logic              new_sel;

    assign resp    = cdc_rdata[r_q.sel*DATA_W +: DATA_W];
    assign new_sel = r_q.stat[6];

    always_comb begin
        r_d       = r_q;
        shd_we    = 1'b0;
        shd_wdata = r_q.data;
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_we) begin
                    unique case (host_addr)
                        OFS_DLO:  r_d.data[BYTE_W-1:0]      = host_wdata;
                        OFS_DHI:  r_d.data[DATA_W-1:BYTE_W] = host_wdata;
                        OFS_STAT: r_d.stat[7:6]             = host_wdata[7:6];
                        default: begin
                            if (present[new_sel]) begin
                                r_d.cmd = host_wdata;
                                r_d.sel = new_sel;
                                if (!host_wdata[0]) begin
                                    r_d.st = ST_WAIT;
                                end else if (host_wdata[7]) begin
                                    r_d.data = '0;
                                    r_d.stat[{new_sel, 1'b1}] = 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end
            default: begin
                if (cdc_ack[r_q.sel]) begin
                    r_d.st = ST_IDLE;
                    shd_we = 1'b1;
                    if (r_q.cmd[7]) begin
                        r_d.data  = resp;
                        shd_wdata = resp;
                        r_d.stat[{r_q.sel, 1'b1}] = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, data: '0, stat: '0, cmd: '0, sel: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == ST_WAIT);
    for (genvar c = 0; c < NCODEC; c++) begin : g_req
        assign cdc_req[c] = busy && (r_q.sel == c[0]);
    end
    assign cdc_wr    = !r_q.cmd[7];
    assign cdc_idx   = r_q.cmd[IDX_W-1:0];
    assign cdc_wdata = r_q.data;
    assign shd_sel   = r_q.sel;
    assign shd_idx   = r_q.cmd[IDX_W-1:0];
    assign data_out  = r_q.data;
    assign stat_out  = r_q.stat;
    assign cmd_out   = r_q.cmd;

    assert_one_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cdc_req));
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_req != '0 && (cdc_req & cdc_ack) == '0) |=>
        ($stable(cdc_req) && $stable(cdc_idx) && $stable(cdc_wdata)));
    assert_req_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_req & ~present) == '0);
    assert_even_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_req != '0) |-> !cdc_idx[0]);
    assert_hw_bits_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_out[5:0] & $past(stat_out[5:0])) == $past(stat_out[5:0])));
    assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cdc_req & cdc_ack) == '0) |=>
        ($stable(data_out) && $stable(stat_out) && $stable(cmd_out)));
endmodule

// File: rtl/ac97_cmd_bridge.sv
module ac97_cmd_bridge
    import acb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [1:0]  codec_present,
    output logic [7:0]  present_status,
    output logic        busy,
    output logic [1:0]  cdc_req,
    output logic        cdc_wr,
    output logic [6:0]  cdc_idx,
    output logic [15:0] cdc_wdata,
    input  logic [1:0]  cdc_ack,
    input  logic [31:0] cdc_rdata,
    input  logic        shd_sel,
    input  logic [6:0]  shd_idx,
    output logic [15:0] shd_rdata
);
    logic [DATA_W-1:0] data_w;
    logic [BYTE_W-1:0] stat_w, cmd_w;
    logic              sw_en, sw_sel;
    logic [IDX_W-1:0]  sw_idx;
    logic [DATA_W-1:0] sw_data;

    acb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .present(codec_present), .cdc_ack(cdc_ack),
        .cdc_rdata(cdc_rdata), .data_out(data_w), .stat_out(stat_w),
        .cmd_out(cmd_w), .busy(busy), .cdc_req(cdc_req), .cdc_wr(cdc_wr),
        .cdc_idx(cdc_idx), .cdc_wdata(cdc_wdata), .shd_we(sw_en),
        .shd_sel(sw_sel), .shd_idx(sw_idx), .shd_wdata(sw_data)
    );

    acb_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(sw_en), .wr_sel(sw_sel),
        .wr_idx(sw_idx), .wr_data(sw_data), .rd_sel(shd_sel),
        .rd_idx(shd_idx), .rd_data(shd_rdata)
    );

    acb_presence u_presence (
        .present(codec_present),
        .status(present_status)
    );

    always_comb begin
        unique case (host_addr)
            OFS_DLO:  host_rdata = data_w[BYTE_W-1:0];
            OFS_DHI:  host_rdata = data_w[DATA_W-1:BYTE_W];
            OFS_CMD:  host_rdata = cmd_w;
            default:  host_rdata = stat_w;
        endcase
    end
endmodule

// File: tb/ac97_cmd_bridge_bench.sv
`timescale 1ns/1ps
module ac97_cmd_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic [1:0]  codec_present = 2'b11;
    logic [7:0]  present_status;
    logic        busy;
    logic [1:0]  cdc_req;
    logic        cdc_wr;
    logic [6:0]  cdc_idx;
    logic [15:0] cdc_wdata;
    logic [1:0]  cdc_ack = 2'b00;
    logic [31:0] cdc_rdata = 32'd0;
    logic        shd_sel = 1'b0;
    logic [6:0]  shd_idx = 7'd0;
    logic [15:0] shd_rdata;

    int tests = 0;
    int fails = 0;
    int acks = 0;
    int lat = 1;
    int cnt = 0;
    logic [15:0] model [2][128];

    always #5 clk = ~clk;

    ac97_cmd_bridge u_ac97_cmd_bridge (.*);

    // Codec model: acknowledge after lat waiting cycles, one cycle wide.
    always @(negedge clk) begin
        if (cdc_ack != 2'b00) begin
            cdc_ack = 2'b00;
        end else if (cdc_req != 2'b00) begin
            if (cnt >= lat) begin
                int c;
                c = cdc_req[1] ? 1 : 0;
                cdc_ack[c] = 1'b1;
                cdc_rdata[c*16 +: 16] = model[c][cdc_idx];
                if (cdc_wr) model[c][cdc_idx] = cdc_wdata;
                acks++;
                cnt = 0;
            end else begin
                cnt++;
            end
        end
    end

    function automatic logic [15:0] init_val(int c, int i);
        return 16'((c + 1) * 16'h1357 + i * 16'h0203);
    endfunction

    function automatic logic [15:0] wr_pat(int c, int i);
        return 16'(i * 16'h3131) ^ (c != 0 ? 16'h5A5A : 16'h0F0F);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic rd_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        host_rd(2'd0, lo);
        host_rd(2'd1, hi);
        w = {hi, lo};
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic shd_rd(input int c, input int i, output logic [15:0] w);
        shd_sel = c[0]; shd_idx = 7'(i);
        #1 w = shd_rdata;
    endtask

    initial begin
        #1000000;
        fails++; tests++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0]  b, st;
        logic [15:0] w, exp;
        int a0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 128; i++) model[c][i] = init_val(c, i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd_word(w);
        check(w == 16'h0, "R1 reset data", w, 0);
        host_rd(2'd3, b);
        check(b == 8'h0, "R7 reset status", b, 0);
        check(busy == 1'b0 && cdc_req == 2'b00, "R9 reset idle", {busy, cdc_req}, 0);

        // R8 presence sweep
        for (int p = 0; p < 4; p++) begin
            codec_present = 2'(p);
            #1;
            exp = 16'({5'd0, p[1], 1'b0, p[0]});
            check(present_status == exp[7:0], "R8 presence", present_status, exp);
        end
        codec_present = 2'b11;

        // R1 data bytes
        host_wr(2'd0, 8'h34);
        host_wr(2'd1, 8'h12);
        rd_word(w);
        check(w == 16'h1234, "R1 data bytes", w, 16'h1234);

        // R3/R5 read sweep over both codecs, all indices
        st = 8'h00;
        for (int c = 0; c < 2; c++) begin
            host_wr(2'd3, c != 0 ? 8'h40 : 8'h00);
            st[7:6] = (c != 0) ? 2'b01 : 2'b00;
            host_rd(2'd3, b);
            check(b == st, "R7 status before reads", b, st);
            for (int i = 0; i < 128; i++) begin
                lat = i % 3;
                a0 = acks;
                host_wr(2'd2, 8'h80 | 8'(i));
                wait_idle();
                rd_word(w);
                st[2*c+1] = 1'b1;
                if (i % 2 == 1) begin
                    check(w == 16'h0, "R5 odd read zero", w, 0);
                    check(acks == a0, "R5 odd read no request", acks - a0, 0);
                end else begin
                    check(w == model[c][i], "R3 even read data", w, model[c][i]);
                    check(acks == a0 + 1, "R3 one request", acks - a0, 1);
                    shd_rd(c, i, w);
                    check(w == model[c][i], "R11 shadow after read", w, model[c][i]);
                end
                host_rd(2'd3, b);
                check(b == st, "R3 valid bit", b, st);
                host_rd(2'd2, b);
                check(b == (8'h80 | 8'(i)), "R1 command readback", b, 8'h80 | 8'(i));
            end
        end

        // R4/R6 write sweep
        for (int c = 0; c < 2; c++) begin
            host_wr(2'd3, c != 0 ? 8'h40 : 8'h00);
            st[7:6] = (c != 0) ? 2'b01 : 2'b00;
            for (int i = 0; i < 128; i++) begin
                lat = (i + 1) % 3;
                exp = wr_pat(c, i);
                host_wr(2'd0, exp[7:0]);
                host_wr(2'd1, exp[15:8]);
                a0 = acks;
                host_wr(2'd2, 8'(i));
                wait_idle();
                rd_word(w);
                check(w == exp, "R6 data kept after write", w, exp);
                if (i % 2 == 1) begin
                    check(acks == a0, "R6 odd write no request", acks - a0, 0);
                    shd_rd(c, i, w);
                    check(w == wr_pat(c, i - 1), "R6 shadow unchanged", w, wr_pat(c, i - 1));
                    check(model[c][i] == init_val(c, i), "R6 codec untouched", model[c][i], init_val(c, i));
                end else begin
                    check(acks == a0 + 1 && model[c][i] == exp, "R4 codec got write", model[c][i], exp);
                    shd_rd(c, i, w);
                    check(w == exp, "R11 shadow after write", w, exp);
                end
                host_rd(2'd3, b);
                check(b == st, "R4 no new valid bit", b, st);
            end
        end

        // R7 host cannot clear hardware bits
        host_wr(2'd3, 8'h3F & 8'h00);
        host_rd(2'd3, b);
        check(b == 8'h0A, "R7 hw bits kept", b, 8'h0A);
        host_wr(2'd3, 8'hC0);
        host_rd(2'd3, b);
        check(b == 8'hCA, "R7 host bits written", b, 8'hCA);
        host_wr(2'd3, 8'h3F);
        host_rd(2'd3, b);
        check(b == 8'h0A, "R7 low bits not host writable", b, 8'h0A);

        // R2 absent codec: select codec 1, mark it absent
        codec_present = 2'b01;
        host_wr(2'd3, 8'h40);
        host_wr(2'd0, 8'h77); host_wr(2'd1, 8'h66);
        host_rd(2'd2, st);
        a0 = acks;
        host_wr(2'd2, 8'h82);
        wait_idle();
        rd_word(w);
        check(w == 16'h6677 && acks == a0, "R2 absent read no effect", w, 16'h6677);
        host_wr(2'd2, 8'h81);
        wait_idle();
        rd_word(w);
        check(w == 16'h6677, "R2 absent odd read no effect", w, 16'h6677);
        host_rd(2'd3, b);
        check(b == 8'h4A, "R2 absent status unchanged", b, 8'h4A);
        host_rd(2'd2, b);
        check(b == st, "R2 command readback unchanged", b, st);
        codec_present = 2'b11;

        // R9 writes ignored while busy
        host_wr(2'd3, 8'h00);
        lat = 8;
        a0 = acks;
        host_wr(2'd2, 8'h84);
        check(busy == 1'b1 && cdc_req == 2'b01, "R9 busy and request", {busy, cdc_req}, 3'b101);
        host_wr(2'd0, 8'hEE);
        host_wr(2'd2, 8'h86);
        host_wr(2'd3, 8'hC0);
        wait_idle();
        rd_word(w);
        check(w == model[0][4], "R9 data from codec only", w, model[0][4]);
        check(acks == a0 + 1, "R9 second command ignored", acks - a0, 1);
        host_rd(2'd2, b);
        check(b == 8'h84, "R9 command kept", b, 8'h84);
        host_rd(2'd3, b);
        check(b == 8'h0A, "R9 status write ignored", b, 8'h0A);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule